// File: doc/BRIEF.md
# Bus Selection Sequencer

This block carries an 8-bit parallel device bus from the end of arbitration through to a live connection with a chosen peer. After arbitration it waits one settle period and reads the data lines. If its own ID is the highest bit set, it goes on to select the peer. For a reselect it acts as the returning target and asserts the bus-busy line itself. Every bus pin it drives is an active-high enable. Logic outside the block inverts each enable onto an open-collector driver.

A host starts a sequence with a one-cycle `start` pulse. The opcode, the two IDs and the timeout setting are captured on that pulse. Sticky flags report the result: connected, lost the bus, or disconnected. They stay set until the host pulses `host_clr`. All pins are plain control and status levels. No streaming data passes through, so no pin has a valid/ready handshake.

Top module: `scsi_selseq`

## Requirements
- R1: After reset every bus enable is low, both mode outputs are low and all three flags are clear.
- R2: After `start`, the block holds busy and its own data bit for ARB_UNITS delay units. It then reads `data_in`. If the highest set bit (bit 7 has top priority) is not `own_id`, all enables drop in the next cycle, `lost_flag` sets and the block goes idle.
- R3: On a win, select and busy are both driven with the own-ID bit for SEL_UNITS delay units. The data enables then carry both the own-ID and the peer-ID bits for DEST_CYC clock cycles, with select and busy still asserted.
- R4: The block then drops busy and keeps select and both ID bits for REL_UNITS delay units. Attention is asserted only for opcode 1 (select with attention) and opcode 2 (select with attention and stop). It is never asserted for opcode 0 (plain select) or opcode 3 (reselect).
- R5: If `bsy_in` is high at the end of that window, a DESKEW_CYC-cycle deskew follows, still driving select and the data bits. After the deskew, select and data drop and `done_flag` sets. `mode_init` rises for opcodes 0 to 2 and `mode_tgt` rises for opcode 3.
- R6: For a reselect, the busy enable is high from the cycle after the peer's busy is seen. It stays high for the whole of target mode.
- R7: If busy is absent, the block waits TO_SCALE × `sel_timeout` delay units. A busy seen in any cycle of that wait goes straight to the deskew.
- R8: When the wait runs out, the data enables drop and the block holds select for ABORT_UNITS more delay units. Busy is checked only at the end of this window. If busy is absent, all enables drop, the block idles and `disc_flag` sets. If busy is present, the block deskews with data cleared and then connects.
- R9: In initiator mode, a low `bsy_in` returns the block to idle in the next cycle. At the same time attention drops and `disc_flag` sets.
- R10: The three flags hold until a `host_clr` pulse. If a flag is set in the same cycle as the clear, the set wins.
- R11: A `start` pulse has no effect unless the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a sequence |
| opcode | input | 2 | 0 select, 1 select+attention, 2 select+attention+stop, 3 reselect |
| own_id | input | 3 | This block's bus ID |
| dest_id | input | 3 | Peer ID |
| sel_timeout | input | 8 | Selection timeout in steps of TO_SCALE delay units |
| bsy_in | input | 1 | Sampled busy line, high when asserted |
| data_in | input | 8 | Sampled data lines, high when asserted |
| host_clr | input | 1 | Clears all sticky flags |
| sel_oe | output | 1 | Select drive enable |
| bsy_oe | output | 1 | Busy drive enable |
| atn_oe | output | 1 | Attention drive enable |
| data_oe | output | 8 | Per-bit data drive enables |
| mode_init | output | 1 | Connected as initiator |
| mode_tgt | output | 1 | Connected as target |
| done_flag | output | 1 | Sticky: connection made |
| lost_flag | output | 1 | Sticky: arbitration check lost |
| disc_flag | output | 1 | Sticky: disconnect or selection abort |

## Verification
The bench builds the block with UNIT_CYC = 2, TO_SCALE = 4 and ABORT_UNITS = 5. With these values one timeout step is 8 cycles and the abort window is 10 cycles. Every phase can then be measured to the exact cycle count within a short run. This covers a busy that arrives partway through the timeout wait, one that arrives late during the abort window, and a full abort that ends in disconnect. The remaining delays keep their default unit counts, so the settle, deskew and hold lengths are checked at their real ratios.

// File: rtl/scsi_selseq_pkg.sv
package scsi_selseq_pkg;
  typedef enum logic [1:0] {
    OP_SEL          = 2'd0,
    OP_SEL_ATN      = 2'd1,
    OP_SEL_ATN_STOP = 2'd2,
    OP_RESEL        = 2'd3
  } sel_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHK,
    ST_ASEL,
    ST_DEST,
    ST_RELB,
    ST_TOWAIT,
    ST_ABORT,
    ST_DESKEW,
    ST_CONN_I,
    ST_CONN_T
  } seq_st_e;
endpackage

// File: rtl/scsi_bus_winner.sv
module scsi_bus_winner #(
  parameter int BUS_W = 8,
  localparam int ID_W = $clog2(BUS_W)
) (
  input  logic [BUS_W-1:0] bus,
  output logic             any,
  output logic [ID_W-1:0]  win_id
);
  // ascending scan: the highest set bit overwrites lower ones
  always_comb begin
    any    = 1'b0;
    win_id = '0;
    for (int i = 0; i < BUS_W; i++) begin
      if (bus[i]) begin
        any    = 1'b1;
        win_id = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/scsi_seq_timer.sv
module scsi_seq_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/scsi_selseq.sv
module scsi_selseq
  import scsi_selseq_pkg::*;
#(
  parameter int UNIT_CYC    = 4,
  parameter int ARB_UNITS   = 1,
  parameter int SEL_UNITS   = 6,
  parameter int DEST_CYC    = 4,
  parameter int REL_UNITS   = 2,
  parameter int DESKEW_CYC  = 2,
  parameter int TO_SCALE    = 8192,
  parameter int ABORT_UNITS = 1000,
  parameter int BUS_W       = 8,
  parameter int TMO_W       = 8,
  parameter int CNT_W       = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [1:0]               opcode,
  input  logic [$clog2(BUS_W)-1:0] own_id,
  input  logic [$clog2(BUS_W)-1:0] dest_id,
  input  logic [TMO_W-1:0]         sel_timeout,
  input  logic                     bsy_in,
  input  logic [BUS_W-1:0]         data_in,
  input  logic                     host_clr,
  output logic                     sel_oe,
  output logic                     bsy_oe,
  output logic                     atn_oe,
  output logic [BUS_W-1:0]         data_oe,
  output logic                     mode_init,
  output logic                     mode_tgt,
  output logic                     done_flag,
  output logic                     lost_flag,
  output logic                     disc_flag
);
  localparam int ID_W = $clog2(BUS_W);
  localparam logic [CNT_W-1:0] L_ARB  = CNT_W'(ARB_UNITS * UNIT_CYC - 1);
  localparam logic [CNT_W-1:0] L_SEL  = CNT_W'(SEL_UNITS * UNIT_CYC - 1);
  localparam logic [CNT_W-1:0] L_DEST = CNT_W'(DEST_CYC - 1);
  localparam logic [CNT_W-1:0] L_REL  = CNT_W'(REL_UNITS * UNIT_CYC - 1);
  localparam logic [CNT_W-1:0] L_DSK  = CNT_W'(DESKEW_CYC - 1);
  localparam logic [CNT_W-1:0] L_ABT  = CNT_W'(ABORT_UNITS * UNIT_CYC - 1);
  localparam logic [CNT_W-1:0] TO_STEP = CNT_W'(TO_SCALE * UNIT_CYC);

  seq_st_e           st_q, st_d;
  sel_op_e           op_q;
  logic [ID_W-1:0]   own_q, dest_q;
  logic [TMO_W-1:0]  tmo_q;
  logic              clr_q;
  logic              ld;
  logic [CNT_W-1:0]  ld_val, tmo_cyc, tmo_ld;
  logic              t_exp;
  logic              win_any;
  logic [ID_W-1:0]   win_id;
  logic              set_done, set_lost, set_disc;
  logic              atn_op, resel;
  logic [BUS_W-1:0]  own_bit, pair_bits;

  scsi_bus_winner #(.BUS_W(BUS_W)) u_win (
    .bus    (data_in),
    .any    (win_any),
    .win_id (win_id)
  );

  scsi_seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ld_val),
    .expired  (t_exp)
  );

  assign atn_op    = (op_q == OP_SEL_ATN) || (op_q == OP_SEL_ATN_STOP);
  assign resel     = (op_q == OP_RESEL);
  assign own_bit   = BUS_W'(1) << own_q;
  assign pair_bits = own_bit | (BUS_W'(1) << dest_q);
  assign tmo_cyc   = TO_STEP * CNT_W'(tmo_q);
  assign tmo_ld    = (tmo_cyc == '0) ? '0 : tmo_cyc - 1'b1;

  always_comb begin
    st_d     = st_q;
    ld       = 1'b0;
    ld_val   = '0;
    set_done = 1'b0;
    set_lost = 1'b0;
    set_disc = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d = ST_CHK; ld = 1'b1; ld_val = L_ARB;
      end
      ST_CHK: if (t_exp) begin
        if (win_any && win_id == own_q) begin
          st_d = ST_ASEL; ld = 1'b1; ld_val = L_SEL;
        end else begin
          st_d = ST_IDLE; set_lost = 1'b1;
        end
      end
      ST_ASEL: if (t_exp) begin
        st_d = ST_DEST; ld = 1'b1; ld_val = L_DEST;
      end
      ST_DEST: if (t_exp) begin
        st_d = ST_RELB; ld = 1'b1; ld_val = L_REL;
      end
      ST_RELB: if (t_exp) begin
        ld = 1'b1;
        if (bsy_in) begin st_d = ST_DESKEW; ld_val = L_DSK; end
        else        begin st_d = ST_TOWAIT; ld_val = tmo_ld; end
      end
      ST_TOWAIT: begin
        if (bsy_in) begin
          st_d = ST_DESKEW; ld = 1'b1; ld_val = L_DSK;
        end else if (t_exp) begin
          st_d = ST_ABORT; ld = 1'b1; ld_val = L_ABT;
        end
      end
      ST_ABORT: if (t_exp) begin
        if (bsy_in) begin
          st_d = ST_DESKEW; ld = 1'b1; ld_val = L_DSK;
        end else begin
          st_d = ST_IDLE; set_disc = 1'b1;
        end
      end
      ST_DESKEW: if (t_exp) begin
        st_d = resel ? ST_CONN_T : ST_CONN_I; set_done = 1'b1;
      end
      ST_CONN_I: if (!bsy_in) begin
        st_d = ST_IDLE; set_disc = 1'b1;
      end
      ST_CONN_T: st_d = ST_CONN_T;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      op_q      <= OP_SEL;
      own_q     <= '0;
      dest_q    <= '0;
      tmo_q     <= '0;
      clr_q     <= 1'b0;
      done_flag <= 1'b0;
      lost_flag <= 1'b0;
      disc_flag <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && start) begin
        op_q   <= sel_op_e'(opcode);
        own_q  <= own_id;
        dest_q <= dest_id;
        tmo_q  <= sel_timeout;
        clr_q  <= 1'b0;
      end else if (st_d == ST_ABORT) begin
        clr_q  <= 1'b1;
      end
      done_flag <= (done_flag & ~host_clr) | set_done;
      lost_flag <= (lost_flag & ~host_clr) | set_lost;
      disc_flag <= (disc_flag & ~host_clr) | set_disc;
    end
  end

  always_comb begin
    sel_oe  = 1'b0;
    bsy_oe  = 1'b0;
    atn_oe  = 1'b0;
    data_oe = '0;
    unique case (st_q)
      ST_CHK:  begin bsy_oe = 1'b1; data_oe = own_bit; end
      ST_ASEL: begin bsy_oe = 1'b1; sel_oe = 1'b1; data_oe = own_bit; end
      ST_DEST: begin bsy_oe = 1'b1; sel_oe = 1'b1; data_oe = pair_bits; end
      ST_RELB, ST_TOWAIT: begin
        sel_oe = 1'b1; atn_oe = atn_op; data_oe = pair_bits;
      end
      ST_ABORT: begin sel_oe = 1'b1; atn_oe = atn_op; end
      ST_DESKEW: begin
        sel_oe  = 1'b1;
        atn_oe  = atn_op;
        bsy_oe  = resel;
        data_oe = clr_q ? '0 : pair_bits;
      end
      ST_CONN_I: atn_oe = atn_op;
      ST_CONN_T: bsy_oe = 1'b1;
      default: ;
    endcase
  end

  assign mode_init = (st_q == ST_CONN_I);
  assign mode_tgt  = (st_q == ST_CONN_T);
endmodule

module scsi_selseq_chk #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bsy_in,
  input logic             host_clr,
  input logic             sel_oe,
  input logic             bsy_oe,
  input logic             atn_oe,
  input logic [BUS_W-1:0] data_oe,
  input logic             mode_init,
  input logic             mode_tgt,
  input logic             done_flag,
  input logic             lost_flag,
  input logic             atn_op
);
  a_r2_lost_releases: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_flag) |-> (!sel_oe && !bsy_oe && !atn_oe && data_oe == '0));

  a_r4_atn_gated: assert property (@(posedge clk) disable iff (!rst_n)
    atn_oe |-> atn_op);

  a_r5_one_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_init && mode_tgt));

  a_r5_release_on_connect: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_init) |-> (!sel_oe && data_oe == '0));

  a_r6_target_drives_bsy: assert property (@(posedge clk) disable iff (!rst_n)
    mode_tgt |-> bsy_oe);

  a_r9_bsy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_init && !bsy_in) |=> (!mode_init && !atn_oe));

  a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !host_clr) |=> done_flag);
endmodule

bind scsi_selseq scsi_selseq_chk #(.BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bsy_in    (bsy_in),
  .host_clr  (host_clr),
  .sel_oe    (sel_oe),
  .bsy_oe    (bsy_oe),
  .atn_oe    (atn_oe),
  .data_oe   (data_oe),
  .mode_init (mode_init),
  .mode_tgt  (mode_tgt),
  .done_flag (done_flag),
  .lost_flag (lost_flag),
  .atn_op    (atn_op)
);

// File: tb/scsi_selseq_test.sv
module scsi_selseq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] opcode = 2'd0;
  logic [2:0] own_id = 3'd0, dest_id = 3'd0;
  logic [7:0] sel_timeout = 8'd0;
  logic       bsy_in = 1'b0;
  logic [7:0] data_in = 8'd0;
  logic       host_clr = 1'b0;
  logic       sel_oe, bsy_oe, atn_oe, mode_init, mode_tgt;
  logic       done_flag, lost_flag, disc_flag;
  logic [7:0] data_oe;
  logic [10:0] obs;
  int checks = 0, fails = 0;

  // bench delays: unit 2 cycles, timeout step 8 cycles, abort 10 cycles
  scsi_selseq #(.UNIT_CYC(2), .TO_SCALE(4), .ABORT_UNITS(5)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .own_id(own_id), .dest_id(dest_id), .sel_timeout(sel_timeout),
    .bsy_in(bsy_in), .data_in(data_in), .host_clr(host_clr),
    .sel_oe(sel_oe), .bsy_oe(bsy_oe), .atn_oe(atn_oe), .data_oe(data_oe),
    .mode_init(mode_init), .mode_tgt(mode_tgt), .done_flag(done_flag),
    .lost_flag(lost_flag), .disc_flag(disc_flag)
  );

  always #4 clk = ~clk;
  assign obs = {sel_oe, bsy_oe, atn_oe, data_oe};

  function automatic logic [10:0] sig(logic s, logic b, logic a, logic [7:0] d);
    return {s, b, a, d};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cw(input logic [10:0] v, output int n);
    n = 0;
    while (obs == v && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0; bsy_in = 1'b0; host_clr = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic kick(input logic [1:0] op, input logic [2:0] own,
                      input logic [2:0] dst, input logic [7:0] tmo);
    opcode = op; own_id = own; dest_id = dst; sel_timeout = tmo;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(obs == 0, "R1 outputs", obs, 0);
    chk({mode_init, mode_tgt, done_flag, lost_flag, disc_flag} == 0, "R1 flags",
        {mode_init, mode_tgt, done_flag, lost_flag, disc_flag}, 0);
  endtask

  task automatic t_lost();
    int n;
    do_reset();
    data_in = 8'h0C;
    kick(2'd0, 3'd2, 3'd5, 8'd3);
    cw(sig(0, 1, 0, 8'h04), n);
    chk(n == 2, "R2 check window", n, 2);
    chk(obs == 0, "R2 release", obs, 0);
    chk(lost_flag && !done_flag, "R2 lost flag", {lost_flag, done_flag}, 2);
  endtask

  task automatic t_select_plain();
    int n;
    do_reset();
    data_in = 8'h04;
    kick(2'd0, 3'd2, 3'd5, 8'd3);
    cw(sig(0, 1, 0, 8'h04), n); chk(n == 2, "R2 arb wait", n, 2);
    cw(sig(1, 1, 0, 8'h04), n); chk(n == 12, "R3 sel settle", n, 12);
    cw(sig(1, 1, 0, 8'h24), n); chk(n == 4, "R3 dest cycles", n, 4);
    bsy_in = 1'b1;
    cw(sig(1, 0, 0, 8'h24), n); chk(n == 6, "R4 R5 release+deskew no atn", n, 6);
    chk(obs == 0, "R5 lines released", obs, 0);
    chk(mode_init && !mode_tgt && done_flag, "R5 initiator done",
        {mode_init, mode_tgt, done_flag}, 5);
  endtask

  task automatic t_select_atn_disc();
    int n;
    do_reset();
    data_in = 8'h04;
    kick(2'd1, 3'd2, 3'd5, 8'd3);
    cw(sig(0, 1, 0, 8'h04), n);
    cw(sig(1, 1, 0, 8'h04), n);
    cw(sig(1, 1, 0, 8'h24), n);
    bsy_in = 1'b1;
    cw(sig(1, 0, 1, 8'h24), n); chk(n == 6, "R4 atn asserted", n, 6);
    chk(obs == sig(0, 0, 1, 8'h00) && mode_init, "R5 connected with atn", obs, 11'h100);
    repeat (3) @(negedge clk);
    bsy_in = 1'b0;
    @(negedge clk);
    chk(!mode_init && obs == 0, "R9 back to idle", {mode_init, obs}, 0);
    chk(disc_flag == 1'b1, "R9 disc flag", disc_flag, 1);
  endtask

  task automatic t_reselect();
    int n;
    do_reset();
    data_in = 8'h41;
    kick(2'd3, 3'd6, 3'd1, 8'd3);
    cw(sig(0, 1, 0, 8'h40), n); chk(n == 2, "R2 highest bit wins", n, 2);
    cw(sig(1, 1, 0, 8'h40), n); chk(n == 12, "R3 resel settle", n, 12);
    cw(sig(1, 1, 0, 8'h42), n); chk(n == 4, "R3 resel dest", n, 4);
    bsy_in = 1'b1;
    cw(sig(1, 0, 0, 8'h42), n); chk(n == 4, "R4 resel release no atn", n, 4);
    cw(sig(1, 1, 0, 8'h42), n); chk(n == 2, "R6 bsy during deskew", n, 2);
    chk(obs == sig(0, 1, 0, 8'h00) && mode_tgt && !mode_init, "R6 target mode",
        obs, 11'h200);
    kick(2'd0, 3'd2, 3'd5, 8'd1);
    repeat (4) @(negedge clk);
    chk(obs == sig(0, 1, 0, 8'h00) && mode_tgt, "R11 start ignored", obs, 11'h200);
  endtask

  task automatic t_timeout_hit();
    int n;
    do_reset();
    data_in = 8'h04;
    kick(2'd0, 3'd2, 3'd5, 8'd3);
    cw(sig(0, 1, 0, 8'h04), n);
    repeat (3) @(negedge clk);
    kick(2'd3, 3'd2, 3'd5, 8'd0);
    cw(sig(1, 1, 0, 8'h04), n); chk(n == 8, "R11 busy start ignored", n, 8);
    cw(sig(1, 1, 0, 8'h24), n);
    repeat (10) @(negedge clk);
    chk(obs == sig(1, 0, 0, 8'h24), "R7 still waiting", obs, 11'h424);
    bsy_in = 1'b1;
    cw(sig(1, 0, 0, 8'h24), n); chk(n == 3, "R7 busy jumps to deskew", n, 3);
    chk(mode_init && done_flag, "R7 connected", {mode_init, done_flag}, 3);
  endtask

  task automatic t_abort_disc();
    int n;
    do_reset();
    data_in = 8'h04;
    kick(2'd2, 3'd2, 3'd5, 8'd2);
    cw(sig(0, 1, 0, 8'h04), n);
    cw(sig(1, 1, 0, 8'h04), n);
    cw(sig(1, 1, 0, 8'h24), n);
    cw(sig(1, 0, 1, 8'h24), n); chk(n == 20, "R7 timeout length", n, 20);
    cw(sig(1, 0, 1, 8'h00), n); chk(n == 10, "R8 abort window", n, 10);
    chk(obs == 0 && !mode_init && !mode_tgt, "R8 released", obs, 0);
    chk(disc_flag && !done_flag, "R8 disc flag", {disc_flag, done_flag}, 2);
    repeat (5) @(negedge clk);
    chk(disc_flag == 1'b1, "R10 flag held", disc_flag, 1);
    host_clr = 1'b1;
    @(negedge clk);
    host_clr = 1'b0;
    chk(disc_flag == 1'b0, "R10 flag cleared", disc_flag, 0);
  endtask

  task automatic t_abort_late();
    int n;
    do_reset();
    data_in = 8'h04;
    kick(2'd0, 3'd2, 3'd5, 8'd1);
    cw(sig(0, 1, 0, 8'h04), n);
    cw(sig(1, 1, 0, 8'h04), n);
    cw(sig(1, 1, 0, 8'h24), n);
    cw(sig(1, 0, 0, 8'h24), n); chk(n == 12, "R7 one step", n, 12);
    repeat (3) @(negedge clk);
    bsy_in = 1'b1;
    cw(sig(1, 0, 0, 8'h00), n); chk(n == 9, "R8 late busy waits for end", n, 9);
    chk(mode_init && done_flag && !disc_flag, "R8 late connect",
        {mode_init, done_flag, disc_flag}, 6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_lost();
    t_select_plain();
    t_select_atn_disc();
    t_reselect();
    t_timeout_hit();
    t_abort_disc();
    t_abort_late();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule